// File: doc/BRIEF.md
# Pipelined ADC Digital Foreground Corrector

This block assembles the final output code of a pipelined converter from the raw decisions of its first three stages, the uncorrected code of the remaining backend stages, and the one-bit pseudo-random dither that the first stage injects. Each of the three corrected stages reports one decision bit per sampling capacitor. Every set bit adds that capacitor's stored weight estimate. The sum is then scaled by the stage's gain term. The first-stage gain term comes in on a port, so a background gain-tracking loop outside the block can update it sample by sample. The second- and third-stage gain terms are stored.

The dither's digital equivalent is removed from the backend part of the sum. Its size is the product of four things: the dither sign, the injection-capacitor weight estimate, the first-stage gain term, and a correction factor. The correction factor is read from a short table indexed by the number of set bits in the stage-2 decision. This table stops leftover stage-2 mismatch from spoiling the dither cancellation. The stage-3 decision plays no part in that lookup.

All coefficients are signed fixed-point words. They are computed off-chip and loaded once through a plain write port. Loading is allowed only while the corrector is held in bypass. The datapath accepts one sample per clock and delivers a rounded, saturated 12-bit code a fixed number of cycles later.

Top module: `pipecal_corrector`

## Requirements
- R1: Each set bit i of `dec1`, `dec2` or `dec3` adds stored weight i of that stage. The stage sum S is multiplied by the stage's gain term G and floored as floor(S*G/2^FRAC_W). Stage 1 uses `gain1`; stages 2 and 3 use their stored gain terms. All sums and products are signed.
- R2: The backend code `back_code` is added as an unsigned whole number of output LSBs, which is back_code*2^FRAC_W in the accumulator.
- R3: The dither term T equals floor(floor(Cd*gain1/2^FRAC_W)*A/2^FRAC_W). Cd is the stored injection weight and A is the selected correction factor. T is subtracted when `dither`=1 and added when `dither`=0.
- R4: The correction factor is table entry k, where k is the number of set bits in `dec2` (0..N2). Bit positions in `dec2` and all bits of `dec3` do not change k.
- R5: `gain1` is sampled together with the other sample inputs. A new value takes effect on the very next sample.
- R6: The accumulated value is rounded half-up to whole LSBs: floor((acc + 2^(FRAC_W-1))/2^FRAC_W).
- R7: The rounded value is saturated to the range 0..2^OUT_W-1 (0..4095).
- R8: A sample presented with `in_valid`=1 and `bypass`=0 at a clock edge appears on `out_code`, with `out_valid`=1, exactly 4 edges later. One sample is accepted per clock.
- R9: A write with `wr_en`=1 changes a coefficient only while `bypass`=1. A write while `bypass`=0 is ignored, and so is an address at or above the map size. No sample is accepted while `bypass`=1. The address map is:
  - 0..N1-1: stage-1 weights
  - N1..N1+N2-1: stage-2 weights
  - next N3 addresses: stage-3 weights
  - then the stage-2 gain, the stage-3 gain and Cd
  - then N2+1 correction factors, indexed by k
- R10: After reset, `out_valid` is 0, every weight and Cd is 0, and both stored gains and all correction factors are 1.0 (2^FRAC_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Holds the corrector idle and opens the coefficient write port |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | ADDR_W | Coefficient address |
| wr_data | input | COEF_W | Signed coefficient value |
| in_valid | input | 1 | Sample present |
| dec1 | input | N1 | Stage-1 capacitor decision bits |
| dec2 | input | N2 | Stage-2 capacitor decision bits |
| dec3 | input | N3 | Stage-3 capacitor decision bits |
| back_code | input | BACK_W | Uncorrected backend code |
| dither | input | 1 | Stage-1 dither level (1 = positive) |
| gain1 | input | COEF_W | Run-time stage-1 gain term |
| out_valid | output | 1 | Corrected code present |
| out_code | output | OUT_W | Corrected, rounded, saturated code |

## Verification
The first sample runs with reset coefficients, so only the backend code reaches the output. This isolates the backend path from every weight. Thermometer codes of several lengths, with alternating dither, then confirm each stage's weight sum and the sign of the dither term. Two `dec2` words with the same bit count but different positions, paired with varied `dec3`, show that only the count selects the correction factor. A changing `gain1`, half-LSB fractions on both sides of the rounding point, and overdriven and underdriven sums separate the gain, rounding and clamp logic. A random burst checks the per-sample latency, and writes outside bypass and outside the map must leave later results unchanged.

// File: rtl/pipecal_pkg.sv
package pipecal_pkg;

  // number of set bits in a decision word
  function automatic int count_ones(input logic [31:0] v);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  // coefficient map: weights of stages 1..3, two gains, dither weight, factors
  function automatic int gain2_addr(input int n1, input int n2, input int n3);
    return n1 + n2 + n3;
  endfunction

  function automatic int gain3_addr(input int n1, input int n2, input int n3);
    return n1 + n2 + n3 + 1;
  endfunction

  function automatic int cd_addr(input int n1, input int n2, input int n3);
    return n1 + n2 + n3 + 2;
  endfunction

  function automatic int alpha_addr(input int n1, input int n2, input int n3);
    return n1 + n2 + n3 + 3;
  endfunction

endpackage

// File: rtl/pipecal_coef_bank.sv
module pipecal_coef_bank #(
  parameter int N1     = 6,
  parameter int N2     = 6,
  parameter int N3     = 6,
  parameter int COEF_W = 20,
  parameter int FRAC_W = 8,
  localparam int NREG  = N1 + N2 + N3 + 3 + N2 + 1,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bypass,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [COEF_W-1:0] wr_data,
  output logic [NREG*COEF_W-1:0]   coef_flat
);
  import pipecal_pkg::*;

  localparam int G2A = gain2_addr(N1, N2, N3);
  localparam int G3A = gain3_addr(N1, N2, N3);
  localparam int ALA = alpha_addr(N1, N2, N3);

  for (genvar e = 0; e < NREG; e++) begin : g_reg
    localparam bit UNITY = ((e == G2A) || (e == G3A) || (e >= ALA));
    localparam logic signed [COEF_W-1:0] RV = UNITY ? COEF_W'(1 << FRAC_W) : '0;

    logic signed [COEF_W-1:0] q;
    logic                     en;

    always_comb begin
      en = wr_en & bypass & (wr_addr == AW'(e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RV;
      else if (en) q <= wr_data;
    end

    assign coef_flat[e*COEF_W +: COEF_W] = q;
  end

endmodule

// File: rtl/pipecal_stage_sum.sv
module pipecal_stage_sum #(
  parameter int NC     = 6,
  parameter int COEF_W = 20,
  parameter int SUM_W  = 25
) (
  input  logic [NC-1:0]           dec,
  input  logic [NC*COEF_W-1:0]    wts,
  output logic signed [SUM_W-1:0] sum
);
  logic signed [SUM_W-1:0] term [NC];

  for (genvar g = 0; g < NC; g++) begin : g_term
    assign term[g] = dec[g] ? SUM_W'($signed(wts[g*COEF_W +: COEF_W])) : '0;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NC; i++) sum = sum + term[i];
  end

endmodule

// File: rtl/pipecal_round_sat.sv
module pipecal_round_sat #(
  parameter int ACC_W  = 64,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic [OUT_W-1:0]        code
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXS = ACC_W'((1 << OUT_W) - 1);

  logic signed [ACC_W-1:0] whole;

  always_comb begin
    whole = (acc + HALF) >>> FRAC_W;
    if (whole < 0)         code = '0;
    else if (whole > MAXS) code = '1;
    else                   code = whole[OUT_W-1:0];
  end

endmodule

// File: rtl/pipecal_corrector.sv
module pipecal_corrector #(
  parameter int N1      = 6,
  parameter int N2      = 6,
  parameter int N3      = 6,
  parameter int BACK_W  = 6,
  parameter int COEF_W  = 20,
  parameter int FRAC_W  = 8,
  parameter int OUT_W   = 12,
  localparam int NREG   = N1 + N2 + N3 + 3 + N2 + 1,
  localparam int ADDR_W = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bypass,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic                     in_valid,
  input  logic [N1-1:0]            dec1,
  input  logic [N2-1:0]            dec2,
  input  logic [N3-1:0]            dec3,
  input  logic [BACK_W-1:0]        back_code,
  input  logic                     dither,
  input  logic signed [COEF_W-1:0] gain1,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_code
);
  import pipecal_pkg::*;

  localparam int SUM_W  = COEF_W + 5;
  localparam int PROD_W = SUM_W + COEF_W;
  localparam int DT_W   = PROD_W + COEF_W;
  localparam int ACC_W  = DT_W + 2;
  localparam int G2A    = gain2_addr(N1, N2, N3);
  localparam int G3A    = gain3_addr(N1, N2, N3);
  localparam int CDA    = cd_addr(N1, N2, N3);
  localparam int ALA    = alpha_addr(N1, N2, N3);

  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_sn = rsync[1];

  // ---------------- coefficients
  logic [NREG*COEF_W-1:0]  coef_flat;
  logic signed [COEF_W-1:0] g2_c, g3_c, cd_c;

  pipecal_coef_bank #(
    .N1(N1), .N2(N2), .N3(N3), .COEF_W(COEF_W), .FRAC_W(FRAC_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_sn), .bypass(bypass), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .coef_flat(coef_flat)
  );

  assign g2_c = $signed(coef_flat[G2A*COEF_W +: COEF_W]);
  assign g3_c = $signed(coef_flat[G3A*COEF_W +: COEF_W]);
  assign cd_c = $signed(coef_flat[CDA*COEF_W +: COEF_W]);

  // ---------------- stage A: weight sums and factor lookup
  logic signed [SUM_W-1:0]  s1_n, s2_n, s3_n;
  logic signed [COEF_W-1:0] alpha_n;
  logic                     acc_in;

  pipecal_stage_sum #(.NC(N1), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_sum1 (
    .dec(dec1), .wts(coef_flat[0 +: N1*COEF_W]), .sum(s1_n));
  pipecal_stage_sum #(.NC(N2), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_sum2 (
    .dec(dec2), .wts(coef_flat[N1*COEF_W +: N2*COEF_W]), .sum(s2_n));
  pipecal_stage_sum #(.NC(N3), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_sum3 (
    .dec(dec3), .wts(coef_flat[(N1+N2)*COEF_W +: N3*COEF_W]), .sum(s3_n));

  always_comb begin
    int k;
    k       = count_ones(32'(dec2));
    alpha_n = '0;
    for (int i = 0; i <= N2; i++) begin
      if (k == i) alpha_n = $signed(coef_flat[(ALA+i)*COEF_W +: COEF_W]);
    end
    acc_in = in_valid & ~bypass;
  end

  logic                     a_v;
  logic signed [SUM_W-1:0]  a_s1, a_s2, a_s3;
  logic signed [COEF_W-1:0] a_g1, a_alpha;
  logic [BACK_W-1:0]        a_back;
  logic                     a_dith;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) a_v <= 1'b0;
    else         a_v <= acc_in;
  end

  always_ff @(posedge clk) begin
    if (acc_in) begin
      a_s1    <= s1_n;
      a_s2    <= s2_n;
      a_s3    <= s3_n;
      a_g1    <= gain1;
      a_alpha <= alpha_n;
      a_back  <= back_code;
      a_dith  <= dither;
    end
  end

  // ---------------- stage B: gain products
  logic signed [PROD_W-1:0] c1_n, c2_n, c3_n, dg_n;

  always_comb begin
    c1_n = (PROD_W'(a_s1) * PROD_W'(a_g1)) >>> FRAC_W;
    c2_n = (PROD_W'(a_s2) * PROD_W'(g2_c)) >>> FRAC_W;
    c3_n = (PROD_W'(a_s3) * PROD_W'(g3_c)) >>> FRAC_W;
    dg_n = (PROD_W'(cd_c) * PROD_W'(a_g1)) >>> FRAC_W;
  end

  logic                     b_v;
  logic signed [PROD_W-1:0] b_c1, b_c2, b_c3, b_dg;
  logic signed [COEF_W-1:0] b_alpha;
  logic [BACK_W-1:0]        b_back;
  logic                     b_dith;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) b_v <= 1'b0;
    else         b_v <= a_v;
  end

  always_ff @(posedge clk) begin
    if (a_v) begin
      b_c1    <= c1_n;
      b_c2    <= c2_n;
      b_c3    <= c3_n;
      b_dg    <= dg_n;
      b_alpha <= a_alpha;
      b_back  <= a_back;
      b_dith  <= a_dith;
    end
  end

  // ---------------- stage C: partial sum and dither term
  logic signed [ACC_W-1:0] part_n;
  logic signed [DT_W-1:0]  dt_n;

  always_comb begin
    part_n = ACC_W'(b_c1) + ACC_W'(b_c2) + ACC_W'(b_c3)
           + (ACC_W'($signed({1'b0, b_back})) <<< FRAC_W);
    dt_n   = (DT_W'(b_dg) * DT_W'(b_alpha)) >>> FRAC_W;
  end

  logic                    c_v;
  logic signed [ACC_W-1:0] c_part;
  logic signed [DT_W-1:0]  c_dt;
  logic                    c_dith;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) c_v <= 1'b0;
    else         c_v <= b_v;
  end

  always_ff @(posedge clk) begin
    if (b_v) begin
      c_part <= part_n;
      c_dt   <= dt_n;
      c_dith <= b_dith;
    end
  end

  // ---------------- stage D: dither removal, rounding, clamp
  logic signed [ACC_W-1:0] acc_n;
  logic [OUT_W-1:0]        code_n;

  always_comb begin
    acc_n = c_part + (c_dith ? -ACC_W'(c_dt) : ACC_W'(c_dt));
  end

  pipecal_round_sat #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_rs (
    .acc(acc_n), .code(code_n));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) out_valid <= 1'b0;
    else         out_valid <= c_v;
  end

  always_ff @(posedge clk) begin
    if (c_v) out_code <= code_n;
  end

endmodule

// File: rtl/pipecal_checker.sv
module pipecal_checker #(
  parameter int NREG   = 28,
  parameter int AW     = 5,
  parameter int COEF_W = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bypass,
  input logic                   in_valid,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [COEF_W-1:0]      wr_data,
  input logic                   out_valid,
  input logic [NREG*COEF_W-1:0] coef_flat
);
  // cycles since reset release, saturating; covers the reset synchroniser
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 7) since_rst <= since_rst + 3'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 7) |-> (out_valid == $past(in_valid && !bypass, 4))); // R8

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bypass) |=> $stable(coef_flat)); // R9

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 7 && wr_en && bypass && (int'(wr_addr) < NREG))
      |=> (coef_flat[$past(wr_addr)*COEF_W +: COEF_W] == $past(wr_data))); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R10

endmodule

bind pipecal_corrector pipecal_checker #(
  .NREG(NREG), .AW(ADDR_W), .COEF_W(COEF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .out_valid(out_valid), .coef_flat(coef_flat)
);

// File: tb/pipecal_corrector_bench.sv
module pipecal_corrector_bench;
  localparam int N1 = 6, N2 = 6, N3 = 6, BACK_W = 6, COEF_W = 20, FRAC_W = 8, OUT_W = 12;
  localparam int NREG = N1 + N2 + N3 + 3 + N2 + 1;
  localparam int AW = $clog2(NREG);
  localparam longint U = 256;
  localparam int G2A = 18, G3A = 19, CDA = 20, ALA = 21;

  logic clk = 1'b0, rst_n = 1'b0, bypass = 1'b0, wr_en = 1'b0, in_valid = 1'b0, dither = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic signed [COEF_W-1:0] wr_data = '0, gain1 = '0;
  logic [N1-1:0] dec1 = '0;
  logic [N2-1:0] dec2 = '0;
  logic [N3-1:0] dec3 = '0;
  logic [BACK_W-1:0] back_code = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_code;

  pipecal_corrector u_pipecal_corrector (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .dec1(dec1), .dec2(dec2), .dec3(dec3),
    .back_code(back_code), .dither(dither), .gain1(gain1),
    .out_valid(out_valid), .out_code(out_code));

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0, live = 1'b0;
  longint mw [NREG];
  longint exp_q[$];
  int     cyc_q[$];
  string  tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint model(logic [N1-1:0] d1, logic [N2-1:0] d2, logic [N3-1:0] d3,
                                   int back, bit dith, longint g1);
    longint s1, s2, s3, acc, dg, dt, r;
    int k;
    s1 = 0; s2 = 0; s3 = 0; k = 0;
    for (int i = 0; i < N1; i++) if (d1[i]) s1 += mw[i];
    for (int i = 0; i < N2; i++) if (d2[i]) begin s2 += mw[N1+i]; k++; end
    for (int i = 0; i < N3; i++) if (d3[i]) s3 += mw[N1+N2+i];
    acc = ((s1 * g1) >>> FRAC_W) + ((s2 * mw[G2A]) >>> FRAC_W)
        + ((s3 * mw[G3A]) >>> FRAC_W) + (longint'(back) <<< FRAC_W);
    dg = (mw[CDA] * g1) >>> FRAC_W;
    dt = (dg * mw[ALA+k]) >>> FRAC_W;
    acc = dith ? acc - dt : acc + dt;
    r = (acc + (U / 2)) >>> FRAC_W;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic wr(int a, longint d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = COEF_W'(d);
    if (bypass && a < NREG) mw[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(logic [N1-1:0] d1, logic [N2-1:0] d2, logic [N3-1:0] d3,
                      int back, bit dith, longint g1, string tag);
    @(negedge clk);
    in_valid = 1'b1; dec1 = d1; dec2 = d2; dec3 = d3;
    back_code = BACK_W'(back); dither = dith; gain1 = COEF_W'(g1);
    if (!bypass) begin
      exp_q.push_back(model(d1, d2, d3, back, dith, g1));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (live && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9: unexpected out_valid, code=%0d expected no output", out_code);
      end else begin
        longint e; int c; string t;
        e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
        tests++;
        if (longint'(out_code) != e) begin
          fails++;
          $display("FAIL %s: code=%0d expected %0d", t, out_code, e);
        end
        tests++;
        if (cyc - c != 4) begin
          fails++;
          $display("FAIL R8: latency=%0d expected 4", cyc - c);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, done=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) mw[i] = (i == G2A || i == G3A || i >= ALA) ? U : 0;
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R10: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    live = 1'b1;

    // R10/R2: reset coefficients leave only the backend code
    send('1, '1, '1, 37, 1'b1, U, "R10");
    send('0, '0, '0, 63, 1'b0, U, "R2");
    idle(6);

    // R9: program in bypass; samples during bypass give no output
    bypass = 1'b1;
    for (int i = 0; i < N1; i++) wr(i, 512 * U + i * 37 - 90);
    for (int i = 0; i < N2; i++) wr(N1 + i, 64 * U + i * 11 - 20);
    for (int i = 0; i < N3; i++) wr(N1 + N2 + i, 8 * U + i * 5 - 7);
    wr(G2A, U + 3);
    wr(G3A, U - 2);
    wr(CDA, 32 * U + 50);
    for (int k = 0; k <= N2; k++) wr(ALA + k, U + 4 * k - 6);
    wr(30, 999);  // outside map, ignored (R9)
    send('1, '1, '1, 5, 1'b0, U, "R9");
    idle(6);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R9: out_valid=%b expected 0 in bypass", out_valid);
    end
    bypass = 1'b0;
    wr(0, 12345);  // bypass low: ignored (R9)

    // R1/R3: thermometer codes, alternating dither
    for (int n = 0; n <= 6; n++)
      send(N1'((1 << n) - 1), N2'((1 << (6 - n)) - 1), N3'((1 << n) - 1),
           n * 9, n[0], U, "R1/R3");
    send(6'b000001, '0, '0, 0, 1'b0, U, "R9 ignored write");
    // R4: same count, other positions, varied stage 3
    send(6'b000111, 6'b000011, 6'b101010, 20, 1'b1, U, "R4");
    send(6'b000111, 6'b110000, 6'b010101, 20, 1'b1, U, "R4");
    send(6'b000111, 6'b100001, 6'b000000, 20, 1'b0, U, "R4");
    // R5: gain1 per sample
    send(6'b001111, 6'b000111, 6'b000001, 30, 1'b0, 250, "R5");
    send(6'b001111, 6'b000111, 6'b000001, 30, 1'b0, 262, "R5");
    // R7: clamp high and low
    send('1, '1, '1, 63, 1'b0, 2 * U, "R7 high");
    send('0, '0, '0, 0, 1'b1, U, "R7 low");
    // R8: random burst, one per clock
    for (int i = 0; i < 24; i++)
      send(N1'($urandom), N2'($urandom), N3'($urandom), int'($urandom_range(0, 63)),
           1'($urandom), longint'($urandom_range(240, 272)), "R8 burst");
    idle(8);

    // R6: half-LSB rounding with dither weight cleared
    bypass = 1'b1;
    wr(CDA, 0);
    wr(G3A, U);
    wr(N1 + N2, 128);
    bypass = 1'b0;
    send('0, '0, 6'b000001, 10, 1'b0, U, "R6 half up");
    idle(6);
    bypass = 1'b1;
    wr(N1 + N2, 127);
    bypass = 1'b0;
    send('0, '0, 6'b000001, 10, 1'b1, U, "R6 below half");
    idle(8);

    tests++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R8: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule